// File: doc/BRIEF.md
# Translation Lookaside Buffer With Global Entries

This block keeps a small, fully associative set of recent translations from a 20-bit linear page number to a 20-bit physical frame number, together with a write permission bit, a user permission bit and a global marker. It sits in front of a page table walker. A lookup is answered on the next clock with a hit and the stored frame and permissions. A miss raises a request to the walker, which carries the page number. When the walk completes, the walker hands back the result on the fill port and the block installs it.

Three kinds of invalidation can be requested. A write of the page-directory root register drops every entry. A non-global flush drops only the entries not marked global. A single-page invalidate drops the entry that holds a given page number. The fill victim is chosen without duplicates: the fill reuses an entry that already holds the same tag, or else takes the lowest free slot, or else takes the slot named by a round-robin pointer.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid and `respValid` and `missReq` are low, so the first lookup of any page misses.
- R2: A lookup presented with `lookupValid` high at a clock edge is answered in the following cycle with `respValid` high, `respHit`, and on a hit the stored `respPfn`, `respWrite` and `respUser`. `respValid` is low in a cycle that follows an edge with no lookup.
- R3: On a miss `respHit` is low, `missReq` is high in the same cycle, and `missVpn` equals the looked-up page number.
- R4: A fill writes a valid entry holding its page number, frame number, write, user and global bits. Later lookups of that page hit and return those values.
- R5: A fill whose page number matches a valid entry overwrites that entry in place. No two valid entries ever hold the same page number, and the other entries are left intact.
- R6: A fill with no matching tag goes to the lowest-index invalid entry. When all 16 entries are valid, it goes to the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one, modulo 16, only when it supplies the victim.
- R7: `rootWrite` invalidates every entry, global ones included.
- R8: `flushNonGlobal` invalidates every entry whose global bit is 0 and leaves global entries valid and unchanged.
- R9: `invalPage` invalidates the valid entry whose page number equals `invalVpn`, global or not, and leaves the others alone. If several flush commands are high together, the union of their effects applies.
- R10: When a flush command and a fill occur in the same cycle, the flush is applied first and the fill is written afterwards, so the filled entry survives the flush.
- R11: A lookup in the same cycle as a flush or a fill is answered from the contents held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVpn | input | 20 | Page number to translate |
| respValid | output | 1 | Lookup answer is present this cycle |
| respHit | output | 1 | The answered lookup hit |
| respPfn | output | 20 | Frame number on a hit |
| respWrite | output | 1 | Write permission on a hit |
| respUser | output | 1 | User permission on a hit |
| missReq | output | 1 | Walk request for the missed page |
| missVpn | output | 20 | Page number the walker must resolve |
| fillValid | input | 1 | Walk result strobe |
| fillVpn | input | 20 | Page number of the walk result |
| fillPfn | input | 20 | Frame number of the walk result |
| fillWrite | input | 1 | Write permission of the walk result |
| fillUser | input | 1 | User permission of the walk result |
| fillGlobal | input | 1 | Marks the new entry as global |
| rootWrite | input | 1 | Root register written: drop all entries |
| flushNonGlobal | input | 1 | Drop all entries not marked global |
| invalPage | input | 1 | Drop the entry for `invalVpn` |
| invalVpn | input | 20 | Page number for a single-page invalidate |

## Verification
The flush assertions assume that no fill occurs in the cycle they watch, because a same-cycle fill legally adds a valid entry back. The bench keeps every flush it uses to test R7, R8 and R9 alone in its cycle, and it covers the combined cases of R10 and R11 with lookups at the ports. The no-duplicate invariant assumes the walker only ever fills through the fill port, which is the only write path the stimulus uses. Lookups are issued one per cycle or spaced apart, and the monitor pairs each answer with the request queued in order.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TlbEntries = 16;
  localparam int VpnW       = 20;
  localparam int PfnW       = 20;
  localparam int IdxW       = $clog2(TlbEntries);

  typedef struct packed {
    logic            valid;
    logic            global;
    logic [VpnW-1:0] vpn;
    logic [PfnW-1:0] pfn;
    logic            wr;
    logic            usr;
  } tlbEntryT;

  // strobes from control to datapath
  typedef struct packed {
    logic [TlbEntries-1:0] clearVec;
    logic                  fillWe;
    logic [IdxW-1:0]       fillIdx;
  } tlbStrobeT;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rootWrite,
  input  logic                  flushNonGlobal,
  input  logic                  invalPage,
  input  logic                  fillValid,
  input  logic [TlbEntries-1:0] validVec,
  input  logic [TlbEntries-1:0] globalVec,
  input  logic [TlbEntries-1:0] fillHitVec,
  input  logic [TlbEntries-1:0] invalHitVec,
  output tlbStrobeT             strobe
);
  logic [TlbEntries-1:0] clearVec, keptVec, dupVec;
  logic [IdxW-1:0]       dupIdx, freeIdx, rrPtr;
  logic                  dupAny, freeAny, useRr;

  // flush is resolved first; fill selection looks at what survives it
  always_comb begin
    clearVec = '0;
    if (rootWrite)      clearVec = clearVec | {TlbEntries{1'b1}};
    if (flushNonGlobal) clearVec = clearVec | ~globalVec;
    if (invalPage)      clearVec = clearVec | invalHitVec;
  end

  assign keptVec = validVec & ~clearVec;
  assign dupVec  = keptVec & fillHitVec;
  assign dupAny  = |dupVec;
  assign freeAny = ~(&keptVec);

  always_comb begin
    dupIdx  = '0;
    freeIdx = '0;
    for (int i = TlbEntries - 1; i >= 0; i--) begin
      if (dupVec[i])   dupIdx  = IdxW'(i);
      if (!keptVec[i]) freeIdx = IdxW'(i);
    end
  end

  assign useRr = fillValid && !dupAny && !freeAny;

  always_ff @(posedge clk) begin
    if (!rstN)      rrPtr <= '0;
    else if (useRr) rrPtr <= rrPtr + 1'b1;
  end

  always_comb begin
    strobe.clearVec = clearVec;
    strobe.fillWe   = fillValid;
    if (dupAny)       strobe.fillIdx = dupIdx;
    else if (freeAny) strobe.fillIdx = freeIdx;
    else              strobe.fillIdx = rrPtr;
  end

  // R7: a root write empties the buffer
  a_r7_root_empties: assert property (@(posedge clk) disable iff (!rstN)
    (rootWrite && !fillValid) |=> (validVec == '0));

  // R8: nothing non-global survives a non-global flush
  a_r8_no_nonglobal_left: assert property (@(posedge clk) disable iff (!rstN)
    (flushNonGlobal && !fillValid) |=> ((validVec & ~globalVec) == '0));

  // R8: global entries are kept
  a_r8_globals_kept: assert property (@(posedge clk) disable iff (!rstN)
    (flushNonGlobal && !rootWrite && !invalPage && !fillValid)
      |=> (validVec == $past(validVec & globalVec)));

  // R9: single page invalidate only touches the matching entry
  a_r9_single_page: assert property (@(posedge clk) disable iff (!rstN)
    (invalPage && !rootWrite && !flushNonGlobal && !fillValid)
      |=> (validVec == $past(validVec & ~invalHitVec)));

  // R6: a fill into a full buffer keeps it full
  a_r6_full_stays_full: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !rootWrite && !flushNonGlobal && !invalPage && (&validVec))
      |=> (&validVec));

  // R10: a fill always leaves a valid entry, even beside a flush
  a_r10_fill_survives: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> (validVec != '0));
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  tlbStrobeT             strobe,
  input  logic                  lookupValid,
  input  logic [VpnW-1:0]       lookupVpn,
  input  logic [VpnW-1:0]       fillVpn,
  input  logic [PfnW-1:0]       fillPfn,
  input  logic                  fillWrite,
  input  logic                  fillUser,
  input  logic                  fillGlobal,
  input  logic [VpnW-1:0]       invalVpn,
  output logic [TlbEntries-1:0] validVec,
  output logic [TlbEntries-1:0] globalVec,
  output logic [TlbEntries-1:0] fillHitVec,
  output logic [TlbEntries-1:0] invalHitVec,
  output logic                  respValid,
  output logic                  respHit,
  output logic [PfnW-1:0]       respPfn,
  output logic                  respWrite,
  output logic                  respUser,
  output logic                  missReq,
  output logic [VpnW-1:0]       missVpn
);
  tlbEntryT              entryQ [TlbEntries];
  tlbEntryT              newEntry;
  logic [TlbEntries-1:0] lookHitVec;
  logic                  selHit, selW, selU;
  logic [PfnW-1:0]       selPfn;

  assign newEntry = '{valid: 1'b1, global: fillGlobal, vpn: fillVpn,
                      pfn: fillPfn, wr: fillWrite, usr: fillUser};

  generate
    for (genvar i = 0; i < TlbEntries; i++) begin : g_cmp
      assign validVec[i]    = entryQ[i].valid;
      assign globalVec[i]   = entryQ[i].global;
      assign lookHitVec[i]  = entryQ[i].valid && (entryQ[i].vpn == lookupVpn);
      assign fillHitVec[i]  = (entryQ[i].vpn == fillVpn);
      assign invalHitVec[i] = entryQ[i].valid && (entryQ[i].vpn == invalVpn);
    end
  endgenerate

  // fill written after clear: the write wins for its own slot
  always_ff @(posedge clk) begin
    for (int i = 0; i < TlbEntries; i++) begin
      if (!rstN)
        entryQ[i] <= '0;
      else if (strobe.fillWe && (strobe.fillIdx == IdxW'(i)))
        entryQ[i] <= newEntry;
      else if (strobe.clearVec[i])
        entryQ[i].valid <= 1'b0;
    end
  end

  always_comb begin
    selHit = |lookHitVec;
    selPfn = '0;
    selW   = 1'b0;
    selU   = 1'b0;
    for (int i = 0; i < TlbEntries; i++) begin
      if (lookHitVec[i]) begin
        selPfn = selPfn | entryQ[i].pfn;
        selW   = selW | entryQ[i].wr;
        selU   = selU | entryQ[i].usr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respPfn   <= '0;
      respWrite <= 1'b0;
      respUser  <= 1'b0;
      missVpn   <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && selHit;
      respPfn   <= selPfn;
      respWrite <= selW;
      respUser  <= selU;
      missVpn   <= lookupVpn;
    end
  end

  assign missReq = respValid && !respHit;

  // R5: at most one entry matches any page
  a_r5_no_duplicate: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookHitVec));

  // R2: answer one cycle after the request
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  // R3: the walk request names the page looked up
  a_r3_miss_vpn: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !selHit) |=> (missReq && (missVpn == $past(lookupVpn))));
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            lookupValid,
  input  logic [VpnW-1:0] lookupVpn,
  output logic            respValid,
  output logic            respHit,
  output logic [PfnW-1:0] respPfn,
  output logic            respWrite,
  output logic            respUser,
  output logic            missReq,
  output logic [VpnW-1:0] missVpn,
  input  logic            fillValid,
  input  logic [VpnW-1:0] fillVpn,
  input  logic [PfnW-1:0] fillPfn,
  input  logic            fillWrite,
  input  logic            fillUser,
  input  logic            fillGlobal,
  input  logic            rootWrite,
  input  logic            flushNonGlobal,
  input  logic            invalPage,
  input  logic [VpnW-1:0] invalVpn
);
  tlbStrobeT             strobe;
  logic [TlbEntries-1:0] validVec, globalVec, fillHitVec, invalHitVec;

  tlb_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .rootWrite      (rootWrite),
    .flushNonGlobal (flushNonGlobal),
    .invalPage      (invalPage),
    .fillValid      (fillValid),
    .validVec       (validVec),
    .globalVec      (globalVec),
    .fillHitVec     (fillHitVec),
    .invalHitVec    (invalHitVec),
    .strobe         (strobe)
  );

  tlb_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .lookupValid (lookupValid),
    .lookupVpn   (lookupVpn),
    .fillVpn     (fillVpn),
    .fillPfn     (fillPfn),
    .fillWrite   (fillWrite),
    .fillUser    (fillUser),
    .fillGlobal  (fillGlobal),
    .invalVpn    (invalVpn),
    .validVec    (validVec),
    .globalVec   (globalVec),
    .fillHitVec  (fillHitVec),
    .invalHitVec (invalHitVec),
    .respValid   (respValid),
    .respHit     (respHit),
    .respPfn     (respPfn),
    .respWrite   (respWrite),
    .respUser    (respUser),
    .missReq     (missReq),
    .missVpn     (missVpn)
  );
endmodule

// File: tb/tb_tlb_cache.sv
module tb_tlb_cache;
  logic        clk = 1'b0;
  logic        rstN;
  logic        lookupValid, fillValid, fillWrite, fillUser, fillGlobal;
  logic        rootWrite, flushNonGlobal, invalPage;
  logic [19:0] lookupVpn, fillVpn, fillPfn, invalVpn;
  logic        respValid, respHit, respWrite, respUser, missReq;
  logic [19:0] respPfn, missVpn;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [19:0] vpn;
    logic        hit;
    logic [19:0] pfn;
    logic        w;
    logic        u;
    string       tag;
  } expT;
  expT expQ[$];

  always #4 clk = ~clk;

  tlb_cache dut (.*);

  function automatic logic [19:0] pf(input logic [19:0] v);
    return v ^ 20'hA5A5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pair every answer with the oldest queued expectation
  always @(negedge clk) begin
    if (rstN && !done && respValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2", "unexpected answer", 32'(respValid), 32'h0);
      end else begin
        automatic expT e = expQ.pop_front();
        chk(respHit == e.hit, e.tag, "hit", 32'(respHit), 32'(e.hit));
        if (e.hit) begin
          chk(respPfn == e.pfn, e.tag, "pfn", 32'(respPfn), 32'(e.pfn));
          chk({respWrite, respUser} == {e.w, e.u}, e.tag, "perm",
              32'({respWrite, respUser}), 32'({e.w, e.u}));
          chk(!missReq, e.tag, "missReq on hit", 32'(missReq), 32'h0);
        end else begin
          chk(missReq, "R3", "missReq", 32'(missReq), 32'h1);
          chk(missVpn == e.vpn, "R3", "missVpn", 32'(missVpn), 32'(e.vpn));
        end
      end
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
    lookupValid = 0; fillValid = 0; rootWrite = 0;
    flushNonGlobal = 0; invalPage = 0;
  endtask

  task automatic setLook(input logic [19:0] v, input bit h, input string tag);
    expT e;
    e.vpn = v; e.hit = h; e.pfn = pf(v); e.w = v[0]; e.u = v[1]; e.tag = tag;
    lookupValid = 1; lookupVpn = v;
    expQ.push_back(e);
  endtask

  task automatic look(input logic [19:0] v, input bit h, input string tag);
    setLook(v, h, tag);
    tick();
  endtask

  // pfn and permissions follow the page number so lookups can predict them
  task automatic setFill(input logic [19:0] v, input bit g);
    fillValid = 1; fillVpn = v; fillPfn = pf(v);
    fillWrite = v[0]; fillUser = v[1]; fillGlobal = g;
  endtask

  task automatic fill(input logic [19:0] v, input bit g);
    setFill(v, g);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; lookupValid = 0; fillValid = 0; rootWrite = 0;
    flushNonGlobal = 0; invalPage = 0; lookupVpn = 0; fillVpn = 0;
    fillPfn = 0; fillWrite = 0; fillUser = 0; fillGlobal = 0; invalVpn = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(!respValid, "R1", "respValid after reset", 32'(respValid), 32'h0);
    chk(!missReq, "R1", "missReq after reset", 32'(missReq), 32'h0);
    @(posedge clk); #1;
    look(20'h12345, 0, "R1");

    // R4 install then hit (R2 answer timing through the monitor)
    fill(20'h00010, 0);
    look(20'h00010, 1, "R4");
    look(20'h00011, 0, "R2");

    // R5 same-tag fill overwrites: different pfn/permissions
    fillValid = 1; fillVpn = 20'h00010; fillPfn = 20'h0BEEF;
    fillWrite = 0; fillUser = 1; fillGlobal = 0;
    tick();
    begin
      expT e;
      e.vpn = 20'h00010; e.hit = 1; e.pfn = 20'h0BEEF; e.w = 0; e.u = 1;
      e.tag = "R5";
      lookupValid = 1; lookupVpn = 20'h00010; expQ.push_back(e);
      tick();
    end
    // put the slot back to the predictable pfn
    fill(20'h00010, 0);
    for (int k = 1; k < 16; k++) fill(20'h00100 + 20'(k), k[0]);
    // R5/R6: all 16 present, nothing evicted
    look(20'h00010, 1, "R5");
    for (int k = 1; k < 16; k++) look(20'h00100 + 20'(k), 1, "R6");

    // R6 round robin from 0 when full
    fill(20'h00200, 0);
    look(20'h00010, 0, "R6");
    look(20'h00200, 1, "R6");
    look(20'h00101, 1, "R6");
    fill(20'h00201, 0);
    look(20'h00101, 0, "R6");
    look(20'h00102, 1, "R6");

    // R9 single page invalidate of a global entry
    invalPage = 1; invalVpn = 20'h00105;
    tick();
    look(20'h00105, 0, "R9");
    look(20'h00104, 1, "R9");
    look(20'h00106, 1, "R9");

    // R6 freed slot is taken before the pointer
    fill(20'h00300, 0);
    fill(20'h00301, 0);
    look(20'h00102, 0, "R6");
    look(20'h00103, 1, "R6");
    look(20'h00300, 1, "R6");
    look(20'h00301, 1, "R6");

    // R8 non-global flush keeps globals
    flushNonGlobal = 1;
    tick();
    look(20'h00103, 1, "R8");
    look(20'h0010F, 1, "R8");
    look(20'h00104, 0, "R8");
    look(20'h00300, 0, "R8");
    look(20'h00200, 0, "R8");

    // R10 flush and fill together: fill survives
    flushNonGlobal = 1; setFill(20'h00400, 0);
    tick();
    look(20'h00400, 1, "R10");
    rootWrite = 1; setFill(20'h00500, 1);
    tick();
    look(20'h00500, 1, "R10");
    // R7 root write dropped globals too
    look(20'h00103, 0, "R7");
    look(20'h0010F, 0, "R7");
    look(20'h00400, 0, "R7");

    // R11 lookup beside a flush or fill sees old contents
    fill(20'h00600, 0);
    setLook(20'h00600, 1, "R11"); rootWrite = 1;
    tick();
    look(20'h00600, 0, "R11");
    setLook(20'h00700, 0, "R11"); setFill(20'h00700, 0);
    tick();
    look(20'h00700, 1, "R11");

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(expQ.size() == 0, "R2", "answers outstanding", 32'(expQ.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule